// File: doc/BRIEF.md
# Compressed Stream Parser and Sequencer

This block sits at the front of a dictionary-style decompressor. It accepts the compressed byte stream one byte per cycle through a valid/taken handshake and classifies every byte. Each byte is one of five kinds: a header byte, a control byte, a literal, the first byte of a copy item, or the second byte of a copy item. For every finished item it reports a mode code, the decoded copy length, the hash-table index, and the literal byte where there is one. Downstream stages (hash table, history memory, output memory) act on these fields. This block does not contain those stages.

A stream opens with an 8-byte header that holds the expected output size and a stored-uncompressed flag. In a compressed stream, a 2-byte control word is inserted inline before every run of 16 items. The parser tracks its position in each group and keeps these control bytes away from the data path. A rolling window of the last four data bytes is presented to downstream logic, so the current byte plus four earlier ones can drive mode decisions. A stored stream is passed through with the bypass flag raised. The stream ends on the byte flagged as end-of-stream. `done` then reports whether the decoded output count matches the header size.

The FSM has eight states:
- IDLE waits for `start` and moves to CLEAR.
- CLEAR initialises for `CLEAR_CYCLES` cycles, then moves to HEADER.
- HEADER takes 8 bytes, then moves to CONTROL for a compressed stream or to RAW for a stored stream.
- CONTROL takes the 2 control bytes, then moves to DATA.
- DATA moves to COPY2 on a copy first byte. It moves to CONTROL after the 16th item. Otherwise it stays in DATA.
- COPY2 moves to CONTROL after the 16th item, otherwise back to DATA.
- RAW stays in RAW.
- Any byte flagged end-of-stream moves the FSM to END.
- END moves back to CLEAR on `start`.

Top module: `cstream_parser`

## Requirements
- R1: A `start` pulse in IDLE or END moves the block into a clear phase of `CLEAR_CYCLES` (default 2) cycles. During this phase `in_taken` is low and `done` is cleared. After it, `in_taken` goes high and the header is consumed. `start` is ignored in every other state.
- R2: The first 8 bytes are the header and are reported with class 1. Bytes 0..3 are the output size, least significant byte first. Bit 0 of byte 4 is the stored flag. All other header bits are ignored.
- R3: Every output is registered. A byte accepted at a clock edge is reported by `byte_class`, `item_valid`, `item_mode`, `copy_len`, `hash_idx`, `lit_byte` and `data_hist` right after that same edge. `item_valid` is a one-cycle pulse. Class 0 means no byte was accepted.
- R4: In a compressed stream, a 2-byte control word follows the header, and another follows every 16 completed items. Control bytes are class 2. The low byte comes first. Bit i of the word describes item i of the group: 1 means a 2-byte copy item, 0 means a 1-byte literal.
- R5: A literal byte is reported with class 3, `item_valid`=1, `item_mode`=1, and the byte itself on `lit_byte`.
- R6: The first copy byte is class 4 and does not raise `item_valid`. Its bits [7:4] hold length minus 3, and bits [3:0] hold index bits [11:8]. The second copy byte is class 5 and holds index bits [7:0]. With it, the block raises `item_valid`, `item_mode`=2, `copy_len` in the range 3..18 and the 12-bit `hash_idx`.
- R7: A control byte never raises `item_valid` and never changes `data_hist`.
- R8: `data_hist` holds the last four data bytes (literal, copy and stored bytes), with the newest in bits [7:0]. Header and control bytes are excluded. The window is cleared during the clear phase.
- R9: When the stored flag is set, every byte after the header is reported as class 3, `item_valid`=1, `item_mode`=3, with the byte on `lit_byte`. `bypass` stays high while these bytes are being taken.
- R10: The byte accepted with `in_eos`=1 is the last byte of the stream, even if it falls partway through a group. After it, `in_taken` stays low until the next `start`.
- R11: `done` rises the cycle after the end-of-stream byte if the output count equals the header size. A literal or stored byte counts 1 and a copy counts its length. `done` then holds until the next `start`. If the counts differ, `done` stays low.
- R12: A byte is consumed only when `in_valid` and `in_taken` are both high, and `in_taken` does not depend on `in_valid`. Idle cycles between valid bytes change neither the decoding nor the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new stream (from IDLE or END) |
| in_byte | input | 8 | Stream byte |
| in_valid | input | 1 | `in_byte` is present |
| in_eos | input | 1 | Current byte is the last of the stream |
| in_taken | output | 1 | Block consumes `in_byte` when `in_valid` is high |
| byte_class | output | 3 | 0 none, 1 header, 2 control, 3 literal, 4 copy first, 5 copy second |
| item_valid | output | 1 | One-cycle pulse: an item has completed |
| item_mode | output | 2 | 1 literal, 2 copy, 3 stored literal |
| copy_len | output | 5 | Copy length 3..18 |
| hash_idx | output | 12 | Hash-table index of a copy |
| lit_byte | output | 8 | Literal byte |
| data_hist | output | 32 | Last four data bytes, newest in [7:0] |
| bypass | output | 1 | Stored stream being passed through |
| done | output | 1 | End reached and output count matches header size |

## Verification
Every per-byte result is due exactly one clock edge after the byte is accepted. The bench drives inputs on the falling edge and works out from `in_valid` and `in_taken` whether the next rising edge will take the byte. It checks that byte's expected class, item fields and history window on the following falling edge. `done` and the dropped `in_taken` are checked on the falling edge after the end-of-stream byte. The clear phase is checked on the first three falling edges after `start`: `in_taken` should be low, low, then high. Random idle gaps are inserted between bytes, so none of these checks depends on the data arriving back to back.

// File: rtl/cp_pkg.sv
package cp_pkg;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_HDR  = 3'd1,
        BC_CTRL = 3'd2,
        BC_LIT  = 3'd3,
        BC_CP1  = 3'd4,
        BC_CP2  = 3'd5
    } byte_class_t;

    typedef enum logic [1:0] {
        MD_NONE = 2'd0,
        MD_LIT  = 2'd1,
        MD_COPY = 2'd2,
        MD_RAW  = 2'd3
    } item_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_HEADER,
        S_CONTROL,
        S_DATA,
        S_COPY2,
        S_RAW,
        S_END
    } parse_state_t;

    localparam int unsigned MIN_MATCH = 3;

endpackage

// File: rtl/cp_hdr_capture.sv
module cp_hdr_capture #(
    parameter int SIZE_W    = 32,
    parameter int HDR_BYTES = 8,
    parameter int POS_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [POS_W-1:0]  pos,
    input  logic [7:0]        hbyte,
    output logic [SIZE_W-1:0] size,
    output logic              stored
);
    localparam int SIZE_BYTES = SIZE_W / 8;
    localparam int FLAG_POS   = SIZE_BYTES;

    for (genvar g = 0; g < SIZE_BYTES; g++) begin : g_size
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                size[g*8 +: 8] <= '0;
            end else if (clr) begin
                size[g*8 +: 8] <= '0;
            end else if (we && (pos == POS_W'(g))) begin
                size[g*8 +: 8] <= hbyte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored <= 1'b0;
        end else if (clr) begin
            stored <= 1'b0;
        end else if (we && (pos == POS_W'(FLAG_POS))) begin
            stored <= hbyte[0];
        end
    end

endmodule

// File: rtl/cp_group_tracker.sv
module cp_group_tracker #(
    parameter int ITEMS = 16,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [POS_W-1:0] ctrl_pos,
    input  logic [7:0]       ctrl_byte,
    input  logic             advance,
    output logic             cur_copy,
    output logic             last_item
);
    localparam int CTRL_BYTES = ITEMS / 8;
    localparam int IIDX_W     = $clog2(ITEMS);

    logic [ITEMS-1:0]  ctrl_q;
    logic [IIDX_W-1:0] item_q;

    for (genvar g = 0; g < CTRL_BYTES; g++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[g*8 +: 8] <= '0;
            end else if (ctrl_we && (ctrl_pos == POS_W'(g))) begin
                ctrl_q[g*8 +: 8] <= ctrl_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            item_q <= '0;
        end else if (ctrl_we) begin
            item_q <= '0;
        end else if (advance) begin
            item_q <= item_q + 1'b1;
        end
    end

    assign cur_copy  = ctrl_q[item_q];
    assign last_item = (item_q == IIDX_W'(ITEMS - 1));

    // R4: a new control word is never written while items of the group remain in flight
    AST_CTRL_AFTER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last_item) |=> !advance); // R4

endmodule

// File: rtl/cp_byte_history.sv
module cp_byte_history #(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [8*DEPTH-1:0] window
);
    logic [7:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (clr) begin
                slot_q[g] <= '0;
            end else if (shift) begin
                if (g == 0) begin
                    slot_q[g] <= din;
                end else begin
                    slot_q[g] <= slot_q[g-1];
                end
            end
        end
        assign window[g*8 +: 8] = slot_q[g];
    end

    // R8: window moves by exactly one byte per data byte
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr) |=> (window[7:0] == $past(din))); // R8

endmodule

// File: rtl/cstream_parser.sv
module cstream_parser #(
    parameter int CLEAR_CYCLES = 2,
    parameter int HDR_BYTES    = 8,
    parameter int SIZE_W       = 32,
    parameter int ITEMS        = 16,
    parameter int LEN_W        = 4,
    parameter int HIST_DEPTH   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [7:0]              in_byte,
    input  logic                    in_valid,
    input  logic                    in_eos,
    output logic                    in_taken,
    output logic [2:0]              byte_class,
    output logic                    item_valid,
    output logic [1:0]              item_mode,
    output logic [LEN_W:0]          copy_len,
    output logic [15-LEN_W:0]       hash_idx,
    output logic [7:0]              lit_byte,
    output logic [8*HIST_DEPTH-1:0] data_hist,
    output logic                    bypass,
    output logic                    done
);
    import cp_pkg::*;

    localparam int CTRL_BYTES = ITEMS / 8;
    localparam int IDX_W      = 16 - LEN_W;
    localparam int IDX_HI_W   = 8 - LEN_W;
    localparam int CLEN_W     = LEN_W + 1;
    localparam int POS_W      = $clog2(CLEAR_CYCLES + HDR_BYTES + CTRL_BYTES + 1);

    parse_state_t       state_q, state_d;
    logic [POS_W-1:0]   pos_q;
    logic               accept;
    logic               cur_copy, last_item;
    logic               hdr_stored;
    logic [SIZE_W-1:0]  hdr_size;
    logic [SIZE_W-1:0]  count_q, count_nxt;
    logic [7:0]         cp_hi_q;
    logic [CLEN_W-1:0]  len_dec;
    logic               hist_shift;
    logic               advance;

    byte_class_t        cls_q;
    item_mode_t         mode_q;
    logic               iv_q;
    logic [CLEN_W-1:0]  len_q;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         lit_q;
    logic               done_q;

    assign in_taken = (state_q == S_HEADER) || (state_q == S_CONTROL) ||
                      (state_q == S_DATA)   || (state_q == S_COPY2)   ||
                      (state_q == S_RAW);
    assign accept   = in_valid && in_taken;

    assign len_dec  = CLEN_W'(cp_hi_q[7:IDX_HI_W]) + CLEN_W'(MIN_MATCH);

    // ---------------- sub-blocks ----------------
    cp_hdr_capture #(
        .SIZE_W    (SIZE_W),
        .HDR_BYTES (HDR_BYTES),
        .POS_W     (POS_W)
    ) u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == S_CLEAR),
        .we     (accept && (state_q == S_HEADER)),
        .pos    (pos_q),
        .hbyte  (in_byte),
        .size   (hdr_size),
        .stored (hdr_stored)
    );

    assign advance = accept && (((state_q == S_DATA) && !cur_copy) || (state_q == S_COPY2));

    cp_group_tracker #(
        .ITEMS (ITEMS),
        .POS_W (POS_W)
    ) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (accept && (state_q == S_CONTROL)),
        .ctrl_pos  (pos_q),
        .ctrl_byte (in_byte),
        .advance   (advance),
        .cur_copy  (cur_copy),
        .last_item (last_item)
    );

    assign hist_shift = accept && ((state_q == S_DATA) || (state_q == S_COPY2) ||
                                   (state_q == S_RAW));

    cp_byte_history #(
        .DEPTH (HIST_DEPTH)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == S_CLEAR),
        .shift  (hist_shift),
        .din    (in_byte),
        .window (data_hist)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_END: begin
                if (start) state_d = S_CLEAR;
            end
            S_CLEAR: begin
                if (pos_q == POS_W'(CLEAR_CYCLES - 1)) state_d = S_HEADER;
            end
            S_HEADER: begin
                if (accept) begin
                    if (in_eos) state_d = S_END;
                    else if (pos_q == POS_W'(HDR_BYTES - 1))
                        state_d = hdr_stored ? S_RAW : S_CONTROL;
                end
            end
            S_CONTROL: begin
                if (accept) begin
                    if (in_eos) state_d = S_END;
                    else if (pos_q == POS_W'(CTRL_BYTES - 1)) state_d = S_DATA;
                end
            end
            S_DATA: begin
                if (accept) begin
                    if (in_eos)        state_d = S_END;
                    else if (cur_copy) state_d = S_COPY2;
                    else if (last_item) state_d = S_CONTROL;
                end
            end
            S_COPY2: begin
                if (accept) begin
                    if (in_eos)         state_d = S_END;
                    else if (last_item) state_d = S_CONTROL;
                    else                state_d = S_DATA;
                end
            end
            S_RAW: begin
                if (accept && in_eos) state_d = S_END;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- position counter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (state_d != state_q) begin
            pos_q <= '0;
        end else if ((state_q == S_CLEAR) ||
                     (accept && ((state_q == S_HEADER) || (state_q == S_CONTROL)))) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // ---------------- output count increment ----------------
    always_comb begin
        count_nxt = count_q;
        if (accept) begin
            if ((state_q == S_RAW) || ((state_q == S_DATA) && !cur_copy))
                count_nxt = count_q + 1'b1;
            else if (state_q == S_COPY2)
                count_nxt = count_q + SIZE_W'(len_dec);
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q   <= BC_NONE;
            mode_q  <= MD_NONE;
            iv_q    <= 1'b0;
            len_q   <= '0;
            idx_q   <= '0;
            lit_q   <= '0;
            cp_hi_q <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            cls_q   <= BC_NONE;
            iv_q    <= 1'b0;
            count_q <= (state_q == S_CLEAR) ? '0 : count_nxt;
            if (((state_q == S_IDLE) || (state_q == S_END)) && start) done_q <= 1'b0;
            if (accept) begin
                unique case (state_q)
                    S_HEADER:  cls_q <= BC_HDR;
                    S_CONTROL: cls_q <= BC_CTRL;
                    S_DATA: begin
                        if (cur_copy) begin
                            cls_q   <= BC_CP1;
                            cp_hi_q <= in_byte;
                        end else begin
                            cls_q  <= BC_LIT;
                            iv_q   <= 1'b1;
                            mode_q <= MD_LIT;
                            lit_q  <= in_byte;
                        end
                    end
                    S_COPY2: begin
                        cls_q  <= BC_CP2;
                        iv_q   <= 1'b1;
                        mode_q <= MD_COPY;
                        len_q  <= len_dec;
                        idx_q  <= {cp_hi_q[IDX_HI_W-1:0], in_byte};
                    end
                    S_RAW: begin
                        cls_q  <= BC_LIT;
                        iv_q   <= 1'b1;
                        mode_q <= MD_RAW;
                        lit_q  <= in_byte;
                    end
                    default: cls_q <= BC_NONE;
                endcase
                if (in_eos) done_q <= (state_q != S_HEADER) && (count_nxt == hdr_size);
            end
        end
    end

    assign byte_class = cls_q;
    assign item_mode  = mode_q;
    assign item_valid = iv_q;
    assign copy_len   = len_q;
    assign hash_idx   = idx_q;
    assign lit_byte   = lit_q;
    assign done       = done_q;
    assign bypass     = (state_q == S_RAW);

    // ---------------- assertions ----------------
    AST_CTRL_NO_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_class == 3'(BC_CTRL)) |-> !item_valid); // R7
    AST_CTRL_HIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_class == 3'(BC_CTRL)) |-> $stable(data_hist)); // R7
    AST_COPY_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (item_valid && (item_mode == 2'(MD_COPY))) |->
        ((copy_len >= CLEN_W'(MIN_MATCH)) && (copy_len <= CLEN_W'((1 << LEN_W) + MIN_MATCH - 1)))); // R6
    AST_DONE_AFTER_EOS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(accept && in_eos)); // R11
    AST_DONE_NOT_TAKING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_taken); // R10
    AST_BYPASS_RAW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && item_valid) |-> (item_mode == 2'(MD_RAW))); // R9
    AST_ITEM_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        item_valid |-> $past(in_valid && in_taken)); // R12

endmodule

// File: tb/tb_cstream_parser.sv
module tb_cstream_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_eos = 1'b0;
    logic        in_taken;
    logic [2:0]  byte_class;
    logic        item_valid;
    logic [1:0]  item_mode;
    logic [4:0]  copy_len;
    logic [11:0] hash_idx;
    logic [7:0]  lit_byte;
    logic [31:0] data_hist;
    logic        bypass;
    logic        done;

    always #2 clk = ~clk;

    cstream_parser dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_byte(in_byte),
        .in_valid(in_valid), .in_eos(in_eos), .in_taken(in_taken),
        .byte_class(byte_class), .item_valid(item_valid), .item_mode(item_mode),
        .copy_len(copy_len), .hash_idx(hash_idx), .lit_byte(lit_byte),
        .data_hist(data_hist), .bypass(bypass), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0]  sb    [0:1023];
    int          ecls  [0:1023];
    int          eiv   [0:1023];
    int          emode [0:1023];
    int          elen  [0:1023];
    int          eidx  [0:1023];
    logic [31:0] ehist [0:1023];
    int          n;
    logic [31:0] hist;
    int          total;
    bit          cur_stored;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic int exp_len(input int field);
        return field + 3;
    endfunction

    function automatic logic [31:0] hist_after(input logic [31:0] h, input logic [7:0] b);
        return {h[23:0], b};
    endfunction

    task automatic push(input logic [7:0] b, input int c, input int iv, input int md,
                        input int ln, input int ix);
        sb[n] = b; ecls[n] = c; eiv[n] = iv; emode[n] = md; elen[n] = ln; eidx[n] = ix;
        if (c >= 3) hist = hist_after(hist, b);
        ehist[n] = hist;
        n++;
    endtask

    // kind: 0 random compressed, 1 all copies with extreme lengths, 2 stored, 3 fixed control word
    task automatic build(input int kind, input int nitems, input int size_delta);
        logic [15:0] ctrl;
        int left;
        logic [31:0] sz;
        n = 0; hist = '0; total = 0;
        cur_stored = (kind == 2);
        for (int i = 0; i < 8; i++) push(8'h00, 1, 0, 0, 0, 0);
        if (kind == 2) begin
            for (int i = 0; i < nitems; i++) begin
                push(8'($urandom), 3, 1, 3, 0, 0);
                total++;
            end
        end else begin
            left = nitems;
            while (left > 0) begin
                ctrl = (kind == 1) ? 16'hFFFF : (kind == 3) ? 16'hA5C3 : 16'($urandom);
                push(ctrl[7:0], 2, 0, 0, 0, 0);
                push(ctrl[15:8], 2, 0, 0, 0, 0);
                for (int it = 0; it < 16 && left > 0; it++) begin
                    if (ctrl[it]) begin
                        int f;
                        int ix;
                        f  = (kind == 1) ? ((it % 2) ? 15 : 0) : int'($urandom % 16);
                        ix = int'($urandom % 4096);
                        push({4'(f), 4'(ix >> 8)}, 4, 0, 0, 0, 0);
                        push(8'(ix), 5, 1, 2, exp_len(f), ix);
                        total += exp_len(f);
                    end else begin
                        push(8'($urandom), 3, 1, 1, 0, 0);
                        total++;
                    end
                    left--;
                end
            end
        end
        sz = 32'(total + size_delta);
        sb[0] = sz[7:0]; sb[1] = sz[15:8]; sb[2] = sz[23:16]; sb[3] = sz[31:24];
        sb[4] = {7'($urandom), cur_stored};
        sb[5] = 8'($urandom); sb[6] = 8'($urandom); sb[7] = 8'($urandom);
    endtask

    task automatic begin_stream();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R1", "taken in clear cycle 1", in_taken, 0);
        @(negedge clk);
        chk("R1", "taken in clear cycle 2", in_taken, 0);
        chk("R11", "done cleared by start", done, 0);
        @(negedge clk);
        chk("R1", "taken after clear", in_taken, 1);
    endtask

    task automatic drive(input int gap_pct, input bit exp_done);
        int k = 0;
        bit go;
        while (k < n) begin
            in_byte  = sb[k];
            in_eos   = (k == n - 1);
            in_valid = (int'($urandom % 100) >= gap_pct);
            go = in_valid && in_taken;
            if (!in_valid) in_byte = 8'($urandom);
            @(negedge clk);
            if (go) begin
                chk(ecls[k] == 1 ? "R2" : ecls[k] == 2 ? "R4" : "R3", "byte_class",
                    byte_class, ecls[k]);
                chk(ecls[k] == 2 ? "R7" : "R3", "item_valid", item_valid, eiv[k]);
                chk("R8", "data_hist", data_hist, ehist[k]);
                if (eiv[k] != 0) begin
                    chk(emode[k] == 3 ? "R9" : emode[k] == 2 ? "R6" : "R5", "item_mode",
                        item_mode, emode[k]);
                    if (emode[k] == 2) begin
                        chk("R6", "copy_len", copy_len, elen[k]);
                        chk("R6", "hash_idx", hash_idx, eidx[k]);
                    end else begin
                        chk("R5", "lit_byte", lit_byte, sb[k]);
                    end
                end
                if (k >= 8 && k < n - 1) chk("R9", "bypass", bypass, cur_stored);
                k++;
            end else if (!in_valid) begin
                chk("R12", "no class on idle cycle", byte_class, 0);
            end
        end
        in_valid = 1'b0; in_eos = 1'b0;
        chk("R10", "taken low after end", in_taken, 0);
        chk("R11", "done", done, exp_done);
        @(negedge clk);
        chk("R11", "done held", done, exp_done);
        chk("R10", "taken stays low", in_taken, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R3", "class at reset", byte_class, 0);
        chk("R1", "taken at reset", in_taken, 0);
        chk("R11", "done at reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle not taking", in_taken, 0);

        // directed: full group, fixed control word, back to back
        build(3, 16, 0);   begin_stream(); drive(0, 1'b1);
        // directed: all copies, lengths 3 and 18, with gaps
        build(1, 20, 0);   begin_stream(); drive(30, 1'b1);
        // directed: size mismatch keeps done low
        build(0, 10, 1);   begin_stream(); drive(0, 1'b0);
        // directed: stored stream in bypass
        build(2, 24, 0);   begin_stream(); drive(20, 1'b1);
        // directed: stream ending partway through a group
        build(0, 21, 0);   begin_stream(); drive(10, 1'b1);
        // random streams
        for (int r = 0; r < 8; r++) begin
            int kind;
            kind = (r % 4 == 3) ? 2 : 0;
            build(kind, 1 + int'($urandom % 50), (r == 5) ? -2 : 0);
            begin_stream();
            drive(int'($urandom % 40), r != 5);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule